// File: doc/BRIEF.md
# Cache Hit and Miss Event Counters

This block keeps two saturating event counters that software uses to judge how well an instruction cache performs. One counter tallies lookups that hit and the other tallies lookups that miss. The cache raises a one-cycle strobe for each event. A four-bit control word, held in a register block elsewhere, gates each counter with its own enable and clears each counter with its own clear bit.

A clear bit is level sensitive. Software writes it to 1 and then writes it back to 0. While the bit stays at 1, its counter stays at zero and ignores strobes. The clear bit of a counter sits two bit positions above that counter's enable bit. The hit counter is 32 bits wide and the miss counter is 16 bits wide. Neither counter wraps. Both counter values come from registers and update one clock after the edge that samples the strobe.

Top module: `cache_perf_monitors`

## Requirements
- R1: When `hit_evt` is 1 and control bit 0 (hit enable) is 1 at a rising clock edge, `hit_count` rises by exactly one after that edge. The counter is HIT_W bits wide, 32 by default.
- R2: When `miss_evt` is 1 and control bit 1 (miss enable) is 1 at a rising clock edge, `miss_count` rises by exactly one after that edge. The counter is MISS_W bits wide, 16 by default.
- R3: Once `hit_count` reaches all ones, further enabled hit strobes leave it at all ones. It never wraps to zero.
- R4: Once `miss_count` reaches all ones, further enabled miss strobes leave it at all ones. It never wraps to zero.
- R5: While a counter's enable bit is 0, its strobes have no effect and the counter keeps its value. Clearing the enable bit never clears the value.
- R6: Control bit 2 clears the hit counter and control bit 3 clears the miss counter. Each clear bit is two positions above its enable bit. While a clear bit is 1, its counter reads zero after each edge and ignores strobes.
- R7: When a clear bit and an enabled strobe for the same counter fall in the same cycle, the clear wins and the counter reads zero.
- R8: Each enable bit and each clear bit acts only on its own counter. Both enable bits may be set together, and then both counters count in the same cycle.
- R9: The synchronous active-high `rst` drives both counters to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| hit_evt | input | 1 | One-cycle strobe, one per cache hit |
| miss_evt | input | 1 | One-cycle strobe, one per cache miss |
| ctrl | input | 4 | Bit 0 hit enable, bit 1 miss enable, bit 2 hit clear, bit 3 miss clear |
| hit_count | output | HIT_W | Registered hit tally |
| miss_count | output | MISS_W | Registered miss tally |

## Verification
An enabled strobe and a held clear bit can fall in the same cycle for the same counter. So can a strobe arriving at a counter that already holds its top value. The vector table drives the clear bit together with an active, enabled strobe on consecutive cycles. It expects zero on that counter while the other counter keeps counting. Saturation is provoked in two ways: by streaming miss strobes past 65535 on the default build, and by running a second instance with narrow counters into its limits. That instance then receives a clear on the hit counter while its miss counter is held at the top value, and the bench expects zero on the hit counter with the miss counter still at the top.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  // Control word layout: enables in the low bits, clears CLR_SHIFT above.
  localparam int NUM_CNT   = 2;
  localparam int CLR_SHIFT = 2;
  localparam int CTRL_W    = NUM_CNT + CLR_SHIFT;
  localparam int HIT_IDX   = 0;
  localparam int MISS_IDX  = 1;
endpackage

// File: rtl/perfmon_ctrl_decode.sv
module perfmon_ctrl_decode
  import perfmon_pkg::*;
(
  input  logic [CTRL_W-1:0]  ctrl,
  output logic [NUM_CNT-1:0] cnt_en,
  output logic [NUM_CNT-1:0] cnt_clr
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_field
    assign cnt_en[g]  = ctrl[g];
    assign cnt_clr[g] = ctrl[g + CLR_SHIFT];
  end
endmodule

// File: rtl/perfmon_sat_counter.sv
module perfmon_sat_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             evt,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic at_top;
  logic bump;

  assign at_top = &count;
  assign bump   = en && evt && !at_top;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (bump) begin
      count <= count + ONE;
    end
  end
endmodule

// File: rtl/cache_perf_monitors.sv
module cache_perf_monitors
  import perfmon_pkg::*;
#(
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_evt,
  input  logic              miss_evt,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [HIT_W-1:0]  hit_count,
  output logic [MISS_W-1:0] miss_count
);
  logic [NUM_CNT-1:0] cnt_en;
  logic [NUM_CNT-1:0] cnt_clr;

  perfmon_ctrl_decode dec_i (
    .ctrl    (ctrl),
    .cnt_en  (cnt_en),
    .cnt_clr (cnt_clr)
  );

  perfmon_sat_counter #(.WIDTH(HIT_W)) hit_cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr[HIT_IDX]),
    .en    (cnt_en[HIT_IDX]),
    .evt   (hit_evt),
    .count (hit_count)
  );

  perfmon_sat_counter #(.WIDTH(MISS_W)) miss_cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr[MISS_IDX]),
    .en    (cnt_en[MISS_IDX]),
    .evt   (miss_evt),
    .count (miss_count)
  );
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker
  import perfmon_pkg::*;
#(
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hit_evt,
  input logic              miss_evt,
  input logic [CTRL_W-1:0] ctrl,
  input logic [HIT_W-1:0]  hit_count,
  input logic [MISS_W-1:0] miss_count
);
  localparam logic [HIT_W-1:0]  H1 = {{(HIT_W-1){1'b0}}, 1'b1};
  localparam logic [MISS_W-1:0] M1 = {{(MISS_W-1){1'b0}}, 1'b1};

  assert_hit_step_R1: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && hit_evt && !ctrl[2] && hit_count != '1) |=> hit_count == $past(hit_count) + H1);

  assert_miss_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1] && miss_evt && !ctrl[3] && miss_count != '1) |=> miss_count == $past(miss_count) + M1);

  assert_hit_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_count == '1 && !ctrl[2]) |=> hit_count == '1);

  assert_miss_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (miss_count == '1 && !ctrl[3]) |=> miss_count == '1);

  assert_hit_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] && !ctrl[2]) |=> $stable(hit_count));

  assert_miss_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[1] && !ctrl[3]) |=> $stable(miss_count));

  // R7: the clear wins even when an enabled strobe is present
  assert_hit_clear_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl[2] |=> hit_count == '0);

  assert_miss_clear_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl[3] |=> miss_count == '0);

  assert_sysreset_R9: assert property (@(posedge clk)
    rst |=> (hit_count == '0 && miss_count == '0));
endmodule

bind cache_perf_monitors perfmon_checker #(.HIT_W(HIT_W), .MISS_W(MISS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .hit_evt    (hit_evt),
  .miss_evt   (miss_evt),
  .ctrl       (ctrl),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/cache_perf_monitors_tb_top.sv
module cache_perf_monitors_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit_evt = 1'b0;
  logic        miss_evt = 1'b0;
  logic [3:0]  ctrl = 4'b0000;
  logic [31:0] hit_count;
  logic [15:0] miss_count;

  logic        s_hit = 1'b0;
  logic        s_miss = 1'b0;
  logic [3:0]  s_ctrl = 4'b0000;
  logic [7:0]  s_hit_count;
  logic [3:0]  s_miss_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cache_perf_monitors dut_i (
    .clk(clk), .rst(rst), .hit_evt(hit_evt), .miss_evt(miss_evt),
    .ctrl(ctrl), .hit_count(hit_count), .miss_count(miss_count)
  );

  cache_perf_monitors #(.HIT_W(8), .MISS_W(4)) small_i (
    .clk(clk), .rst(rst), .hit_evt(s_hit), .miss_evt(s_miss),
    .ctrl(s_ctrl), .hit_count(s_hit_count), .miss_count(s_miss_count)
  );

  typedef struct packed {
    logic [3:0]  c;
    logic        h;
    logic        m;
    logic [31:0] eh;
    logic [15:0] em;
  } vec_t;

  // ctrl: [3] miss clear, [2] hit clear, [1] miss enable, [0] hit enable
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 1'b1, 1'b1, 32'd1, 16'd0},  // R1 hit only enabled, R8
    '{4'b0011, 1'b1, 1'b1, 32'd2, 16'd1},  // R2 both enabled together
    '{4'b0010, 1'b1, 1'b1, 32'd2, 16'd2},  // R5 hit disabled keeps value
    '{4'b0000, 1'b1, 1'b1, 32'd2, 16'd2},  // R5 both disabled
    '{4'b0011, 1'b0, 1'b1, 32'd2, 16'd3},  // R2 miss strobe only
    '{4'b0011, 1'b1, 1'b0, 32'd3, 16'd3},  // R1 hit strobe only
    '{4'b0111, 1'b1, 1'b1, 32'd0, 16'd4},  // R7 clear beats strobe, R8
    '{4'b0111, 1'b1, 1'b1, 32'd0, 16'd5},  // R6 held clear ignores strobe
    '{4'b0011, 1'b1, 1'b1, 32'd1, 16'd6},  // R6 counting resumes after release
    '{4'b1011, 1'b1, 1'b1, 32'd2, 16'd0},  // R7 miss clear beats strobe
    '{4'b1111, 1'b1, 1'b1, 32'd0, 16'd0},  // R6 both cleared
    '{4'b0011, 1'b1, 1'b1, 32'd1, 16'd1},  // R8 both count
    '{4'b1100, 1'b0, 1'b0, 32'd0, 16'd0}   // R6 clear without enable
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step();
    step();
    check("R9 reset hit", hit_count, 32'd0);
    check("R9 reset miss", {16'd0, miss_count}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ctrl = VECS[i].c;
      hit_evt = VECS[i].h;
      miss_evt = VECS[i].m;
      step();
      check($sformatf("R1 table %0d hit", i), hit_count, VECS[i].eh);
      check($sformatf("R2 table %0d miss", i), {16'd0, miss_count}, {16'd0, VECS[i].em});
    end

    // R4: push the miss counter to its top value
    ctrl = 4'b0010; hit_evt = 1'b1; miss_evt = 1'b1;
    for (int i = 0; i < 65535; i++) step();
    check("R4 miss at top", {16'd0, miss_count}, 32'd65535);
    for (int i = 0; i < 10; i++) step();
    check("R4 miss stays at top", {16'd0, miss_count}, 32'd65535);
    check("R8 hit untouched", hit_count, 32'd0);
    ctrl = 4'b0000;
    for (int i = 0; i < 3; i++) step();
    check("R5 disabled keeps top", {16'd0, miss_count}, 32'd65535);

    // R9: system reset from a nonzero state
    ctrl = 4'b0011;
    step();
    check("R1 count after enable", hit_count, 32'd1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R9 mid reset hit", hit_count, 32'd0);
    check("R9 mid reset miss", {16'd0, miss_count}, 32'd0);
    hit_evt = 1'b0; miss_evt = 1'b0; ctrl = 4'b0000;

    // R3: narrow instance saturates both counters
    s_ctrl = 4'b0011; s_hit = 1'b1; s_miss = 1'b1;
    for (int i = 0; i < 300; i++) step();
    check("R3 hit at top", {24'd0, s_hit_count}, 32'd255);
    check("R4 small miss at top", {28'd0, s_miss_count}, 32'd15);
    s_ctrl = 4'b0111;
    step();
    check("R7 clear at top", {24'd0, s_hit_count}, 32'd0);
    check("R4 miss stays during hit clear", {28'd0, s_miss_count}, 32'd15);
    s_ctrl = 4'b0011;
    step();
    check("R3 restart after clear", {24'd0, s_hit_count}, 32'd1);

    finish_run();
  end
endmodule